// File: doc/BRIEF.md
# Parallel FIFO Bridge Handshake Master

This block lets on-chip logic move bytes to and from an external USB-to-parallel FIFO bridge over a shared 8-bit bidirectional bus. The bridge exposes two active-low status flags (one saying a received byte is waiting, one saying there is room for a byte to send), an active-low read strobe and an active-high write strobe. The controller watches both flags through synchronizers, picks one access at a time, generates each strobe with a pulse width and recovery gap counted in system clocks, and decides when the bus pad is driven.

Toward the rest of the chip it offers two valid/ready byte streams: one delivering bytes read from the bridge and one accepting bytes to be written to it. All timing limits are given in nanoseconds together with the clock period. They are turned into cycle counts by rounding up. With the default 10 ns clock the read strobe lasts 5 cycles, reads are spaced by at least 13 cycles, the write strobe lasts 5 cycles, and writes are spaced by at least 5 cycles.

Top module: `pbus_fifo_master`

## Requirements
- R1: While `rst` is high at a clock edge, and afterwards until the first access, `rd_n_o` is 1, `wr_o` is 0, `bus_oe_o` is 0, `rx_valid_o` is 0 and `tx_ready_o` is 0. This applies even if the reset lands in the middle of a strobe.
- R2: A read strobe may begin only if all three of these hold:
  - `avail_n_i` was sampled low at the clock edge three edges before `rd_n_o` is first seen low.
  - The receive holding register is empty.
  - No strobe was released within the last BLANK cycles, where BLANK is ceil(25 ns / period) + 3.
- R3: `rd_n_o` stays low for exactly RD_CYC = ceil(50 ns / period) cycles. The byte on `bus_i` is captured at the clock edge that releases the strobe, not earlier.
- R4: Between two read strobes, `rd_n_o` stays high for at least ceil((50 + 80) ns / period) cycles.
- R5: Bytes read from the bridge appear on `rx_data_o` in bridge order. `rx_valid_o` and `rx_data_o` hold while `rx_ready_i` is low, and no further read starts while a byte is held.
- R6: `tx_ready_o` is high only when `tx_valid_i` is high and `space_n_i` was sampled low two edges earlier. A byte is accepted in a cycle where `tx_valid_i` and `tx_ready_o` are both high.
- R7: `wr_o` rises at the edge that accepts a byte and stays high for exactly WR_CYC = ceil(50 ns / period) cycles. `bus_o` carries the accepted byte with `bus_oe_o` high from that edge through one cycle after `wr_o` falls. Bytes are written in acceptance order.
- R8: Between two write strobes, `wr_o` stays low for at least ceil(50 ns / period) cycles.
- R9: `bus_oe_o` is never high while `rd_n_o` is low, and `wr_o` is never high while `rd_n_o` is low.
- R10: When a read and a write are both eligible in the idle state, the controller grants the direction not served by the previous access; the first access after reset favours a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| avail_n_i | input | 1 | Bridge flag, low when a received byte can be fetched |
| space_n_i | input | 1 | Bridge flag, low when a byte may be written |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_o | output | 1 | Write strobe, byte latched by the bridge on its falling edge |
| bus_i | input | 8 | Data bus as seen from the pad |
| bus_o | output | 8 | Data driven toward the pad |
| bus_oe_o | output | 1 | Pad output enable for the data bus |
| rx_data_o | output | 8 | Byte read from the bridge |
| rx_valid_o | output | 1 | `rx_data_o` holds a byte |
| rx_ready_i | input | 1 | Consumer takes the byte |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | `tx_data_i` holds a byte |
| tx_ready_o | output | 1 | Controller accepts the byte this cycle |

## Verification
The assertions check the following on every cycle:
- Strobe widths and recovery gaps, measured with counters.
- That the pad is never driven during a read strobe.
- That a strobe begins only after the matching flag was low at the right synchronizer delay.
- That accepted write data stays stable on the pad, and that received bytes hold under backpressure.

The bench's scenarios are the only place where other behaviour shows:
- Capture at the end of the read strobe rather than at its start, which the bridge model exposes by putting a wrong byte on the bus early in the strobe.
- End-to-end byte order in both directions.
- Round-robin alternation under load.
- Refusal to write while the bridge reports no space.
- Recovery from a reset asserted mid-strobe.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_WR     = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RECOV  = 3'd4
    } pbf_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbf_sync.sv
module pbf_sync #(
    parameter int W       = 2,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg_q[0] <= RST_VAL;
        else     stg_q[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_q[i] <= RST_VAL;
            else     stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pbf_rr_arb.sv
module pbf_rr_arb (
    input  logic rd_req,
    input  logic wr_req,
    input  logic last_rd,
    output logic gnt_rd,
    output logic gnt_wr
);
    // The side served last yields when both ask.
    always_comb begin
        gnt_rd = rd_req && (!wr_req || !last_rd);
        gnt_wr = wr_req && (!rd_req ||  last_rd);
    end
endmodule

// File: rtl/pbus_fifo_master.sv
module pbus_fifo_master
    import pbf_pkg::*;
#(
    parameter int DW            = 8,
    parameter int CLK_NS        = 10,
    parameter int RD_PULSE_NS   = 50,
    parameter int RD_PRE_NS     = 50,
    parameter int FLAG_HOLD_NS  = 80,
    parameter int WR_PULSE_NS   = 50,
    parameter int WR_SETUP_NS   = 20,
    parameter int WR_PRE_NS     = 50,
    parameter int FLAG_RISE_NS  = 25,
    parameter int SYNC_STAGES   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          avail_n_i,
    input  logic          space_n_i,
    output logic          rd_n_o,
    output logic          wr_o,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] bus_o,
    output logic          bus_oe_o,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_valid_o,
    input  logic          rx_ready_i,
    input  logic [DW-1:0] tx_data_i,
    input  logic          tx_valid_i,
    output logic          tx_ready_o
);
    localparam int RD_CYC     = max2(1, cdiv(RD_PULSE_NS, CLK_NS));
    localparam int RD_GAP_CYC = max2(1, cdiv(RD_PRE_NS + FLAG_HOLD_NS, CLK_NS));
    localparam int WR_CYC     = max2(1, max2(cdiv(WR_PULSE_NS, CLK_NS),
                                             cdiv(WR_SETUP_NS, CLK_NS)));
    localparam int WR_GAP_CYC = max2(1, cdiv(WR_PRE_NS, CLK_NS));
    localparam int BLANK_CYC  = cdiv(FLAG_RISE_NS, CLK_NS) + SYNC_STAGES + 1;
    localparam int CNT_MAX    = max2(max2(RD_CYC, RD_GAP_CYC),
                                     max2(max2(WR_CYC, WR_GAP_CYC), BLANK_CYC));
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        pbf_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] blank;
        logic             rd_n;
        logic             wr;
        logic             oe;
        logic [DW-1:0]    dout;
        logic [DW-1:0]    rx_data;
        logic             rx_valid;
        logic             last_rd;
    } regs_t;

    regs_t r_q, r_d;

    logic [1:0] flags_s;
    logic       avail_s, space_s;
    logic       rd_req, wr_req, gnt_rd, gnt_wr;
    logic       flags_open;

    pbf_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({avail_n_i, space_n_i}),
        .q   (flags_s)
    );
    assign avail_s = !flags_s[1];
    assign space_s = !flags_s[0];

    always_comb begin
        flags_open = (r_q.blank == '0) && (r_q.st == ST_IDLE);
        rd_req     = flags_open && avail_s && !r_q.rx_valid;
        wr_req     = flags_open && space_s && tx_valid_i;
    end

    pbf_rr_arb u_arb (
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .last_rd (r_q.last_rd),
        .gnt_rd  (gnt_rd),
        .gnt_wr  (gnt_wr)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.blank != '0) r_d.blank = r_q.blank - 1'b1;
        if (r_q.rx_valid && rx_ready_i) r_d.rx_valid = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (gnt_rd) begin
                    r_d.st      = ST_RD;
                    r_d.rd_n    = 1'b0;
                    r_d.cnt     = CNT_W'(RD_CYC - 1);
                    r_d.last_rd = 1'b1;
                end else if (gnt_wr) begin
                    r_d.st      = ST_WR;
                    r_d.wr      = 1'b1;
                    r_d.oe      = 1'b1;
                    r_d.dout    = tx_data_i;
                    r_d.cnt     = CNT_W'(WR_CYC - 1);
                    r_d.last_rd = 1'b0;
                end
            end
            ST_RD: begin
                if (r_q.cnt == '0) begin
                    r_d.rd_n     = 1'b1;
                    r_d.rx_data  = bus_i;
                    r_d.rx_valid = 1'b1;
                    r_d.blank    = CNT_W'(BLANK_CYC);
                    r_d.cnt      = CNT_W'(RD_GAP_CYC - 1);
                    r_d.st       = ST_RECOV;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WR: begin
                if (r_q.cnt == '0) begin
                    r_d.wr    = 1'b0;
                    r_d.blank = CNT_W'(BLANK_CYC);
                    r_d.st    = ST_WHOLD;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                r_d.oe  = 1'b0;
                r_d.cnt = CNT_W'(WR_GAP_CYC - 1);
                r_d.st  = ST_RECOV;
            end
            ST_RECOV: begin
                if (r_q.cnt == '0) r_d.st  = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st       <= ST_IDLE;
            r_q.cnt      <= '0;
            r_q.blank    <= '0;
            r_q.rd_n     <= 1'b1;
            r_q.wr       <= 1'b0;
            r_q.oe       <= 1'b0;
            r_q.dout     <= '0;
            r_q.rx_data  <= '0;
            r_q.rx_valid <= 1'b0;
            r_q.last_rd  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_n_o     = r_q.rd_n;
    assign wr_o       = r_q.wr;
    assign bus_oe_o   = r_q.oe;
    assign bus_o      = r_q.dout;
    assign rx_data_o  = r_q.rx_data;
    assign rx_valid_o = r_q.rx_valid;
    assign tx_ready_o = gnt_wr;
endmodule

// File: rtl/pbus_fifo_master_chk.sv
module pbus_fifo_master_chk #(
    parameter int DW         = 8,
    parameter int RD_CYC     = 5,
    parameter int RD_GAP_CYC = 13,
    parameter int WR_CYC     = 5,
    parameter int WR_GAP_CYC = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          avail_n_i,
    input logic          space_n_i,
    input logic          rd_n_o,
    input logic          wr_o,
    input logic [DW-1:0] bus_o,
    input logic          bus_oe_o,
    input logic [DW-1:0] rx_data_o,
    input logic          rx_valid_o,
    input logic          rx_ready_i,
    input logic          tx_valid_i,
    input logic          tx_ready_o
);
    localparam int SAT = 1000;
    int rd_lo, rd_hi, wr_hi, wr_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_lo <= 0; rd_hi <= SAT; wr_hi <= 0; wr_lo <= SAT;
        end else begin
            rd_lo <= rd_n_o ? 0 : rd_lo + 1;
            rd_hi <= !rd_n_o ? 0 : ((rd_hi < SAT) ? rd_hi + 1 : SAT);
            wr_hi <= !wr_o ? 0 : wr_hi + 1;
            wr_lo <= wr_o ? 0 : ((wr_lo < SAT) ? wr_lo + 1 : SAT);
        end
    end

    // R2
    a_r2_read_needs_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n_o) |-> !$past(avail_n_i, 3));
    // R3
    a_r3_read_width: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n_o) |-> rd_lo == RD_CYC);
    // R4
    a_r4_read_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n_o) |-> rd_hi >= RD_GAP_CYC);
    // R5
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));
    // R6
    a_r6_tx_ready_gated: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |-> tx_valid_i && !$past(space_n_i, 2));
    // R7
    a_r7_write_width: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_o) |-> wr_hi == WR_CYC && bus_oe_o);
    a_r7_write_data_stable: assert property (@(posedge clk) disable iff (rst)
        wr_o && $past(wr_o) |-> bus_oe_o && $stable(bus_o));
    // R8
    a_r8_write_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_o) |-> wr_lo >= WR_GAP_CYC);
    // R9
    a_r9_no_drive_in_read: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !bus_oe_o && !wr_o);
endmodule

bind pbus_fifo_master pbus_fifo_master_chk #(
    .DW(DW), .RD_CYC(RD_CYC), .RD_GAP_CYC(RD_GAP_CYC),
    .WR_CYC(WR_CYC), .WR_GAP_CYC(WR_GAP_CYC)
) u_chk (
    .clk(clk), .rst(rst), .avail_n_i(avail_n_i), .space_n_i(space_n_i),
    .rd_n_o(rd_n_o), .wr_o(wr_o), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o)
);

// File: tb/tb_pbus_fifo_master.sv
module tb_pbus_fifo_master;
    localparam int CLK_PERIOD = 10;
    localparam int E_RD_CYC = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_RD_GAP = (130 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_WR_CYC = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_WR_GAP = (50 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic clk = 0, rst = 1;
    logic avail_n = 1, space_n = 0;
    logic [7:0] bus_i = 8'hEE;
    logic rx_ready = 0, tx_valid = 0;
    logic [7:0] tx_data = 0;
    logic rd_n_o, wr_o, bus_oe_o, rx_valid_o, tx_ready_o;
    logic [7:0] bus_o, rx_data_o;

    pbus_fifo_master dut (
        .clk(clk), .rst(rst), .avail_n_i(avail_n), .space_n_i(space_n),
        .rd_n_o(rd_n_o), .wr_o(wr_o), .bus_i(bus_i), .bus_o(bus_o),
        .bus_oe_o(bus_oe_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .rx_ready_i(rx_ready), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
        .tx_ready_o(tx_ready_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] rx_src[$], rx_exp[$], tx_src[$], tx_exp[$];
    int rd_lo = 0, rd_hi = 1000, wr_hi = 0, wr_lo = 1000;
    int rxf_busy = 0, txe_busy = 0;
    bit txe_block = 0, prev_rd_n = 1, prev_wr = 0;
    bit tx_xfer = 0, rr_phase = 0;
    int rd_pulses = 0, wr_pulses = 0, last_kind = 0, ready_seen = 0;
    logic [7:0] wr_byte = 0, prev_data = 0;
    bit prev_rxv = 0, prev_rdy = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic log_kind(input int kind);
        if (rr_phase && last_kind != 0)
            chk(kind != last_kind, "R10", "access kind repeats", kind, 3 - last_kind);
        last_kind = kind;
    endtask

    // Sampling away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(!(!rd_n_o && bus_oe_o), "R9", "bus driven in read", bus_oe_o, 0);
            chk(!(!rd_n_o && wr_o), "R9", "both strobes active", wr_o, 0);
            if (prev_rxv && !prev_rdy)
                chk(rx_valid_o && rx_data_o == prev_data, "R5", "held byte moved",
                    rx_data_o, prev_data);
            if (rx_valid_o && rx_ready) begin
                if (rx_exp.size() == 0) chk(0, "R5", "unexpected rx byte", rx_data_o, 0);
                else begin
                    logic [7:0] e;
                    e = rx_exp.pop_front();
                    chk(rx_data_o == e, "R3", "rx byte", rx_data_o, e);
                end
            end
            if (tx_ready_o) begin
                ready_seen++;
                chk(tx_valid, "R6", "ready without valid", tx_valid, 1);
            end
            tx_xfer = tx_valid && tx_ready_o;
            if (tx_xfer) tx_exp.push_back(tx_data);
            prev_rxv = rx_valid_o; prev_rdy = rx_ready; prev_data = rx_data_o;
        end else begin
            tx_xfer = 0; prev_rxv = 0;
        end
    end

    // Bridge model, reacting just after each edge
    always @(posedge clk) begin
        #1;
        if (rxf_busy > 0) rxf_busy--;
        if (txe_busy > 0) txe_busy--;
        if (tx_xfer) begin
            void'(tx_src.pop_front());
            tx_xfer = 0;
        end
        tx_valid = (tx_src.size() > 0);
        tx_data  = (tx_src.size() > 0) ? tx_src[0] : 8'h00;

        if (prev_rd_n && !rd_n_o) begin
            if (!rst) begin
                chk(avail_n == 0, "R2", "read while flag high", avail_n, 0);
                chk(rx_src.size() > 0, "R2", "read with no byte", rx_src.size(), 1);
                chk(rd_hi + 1 >= E_RD_GAP, "R4", "read gap", rd_hi + 1, E_RD_GAP);
            end
            rd_lo = 1; rd_pulses++; log_kind(1);
        end else if (!rd_n_o) begin
            rd_lo++;
        end else if (!prev_rd_n && rd_n_o) begin
            if (!rst) chk(rd_lo == E_RD_CYC, "R3", "read width", rd_lo, E_RD_CYC);
            if (rx_src.size() > 0) rx_exp.push_back(rx_src.pop_front());
            rxf_busy = 11; rd_hi = 0;
        end else if (rd_hi < 1000) rd_hi++;
        bus_i = (!rd_n_o && rd_lo >= 3 && rx_src.size() > 0) ? rx_src[0] : 8'hEE;

        if (!prev_wr && wr_o) begin
            if (!rst) begin
                chk(space_n == 0, "R6", "write while flag high", space_n, 0);
                chk(bus_oe_o, "R7", "bus not driven at rise", bus_oe_o, 1);
                chk(wr_lo + 1 >= E_WR_GAP, "R8", "write gap", wr_lo + 1, E_WR_GAP);
            end
            wr_byte = bus_o; wr_hi = 1; wr_pulses++; log_kind(2);
        end else if (wr_o) begin
            wr_hi++;
            if (!rst) chk(bus_oe_o && bus_o == wr_byte, "R7", "write data moved", bus_o, wr_byte);
        end else if (prev_wr && !wr_o) begin
            if (!rst) begin
                chk(wr_hi == E_WR_CYC, "R7", "write width", wr_hi, E_WR_CYC);
                chk(bus_oe_o, "R7", "no hold after fall", bus_oe_o, 1);
                if (tx_exp.size() == 0) chk(0, "R7", "write with nothing accepted", bus_o, 0);
                else begin
                    logic [7:0] e;
                    e = tx_exp.pop_front();
                    chk(bus_o == e, "R7", "written byte", bus_o, e);
                end
            end
            txe_busy = 11; wr_lo = 0;
        end else if (wr_lo < 1000) wr_lo++;

        if (rxf_busy <= 9) avail_n = (rxf_busy > 0) || (rx_src.size() == 0);
        if (txe_busy <= 9) space_n = (txe_busy > 0) || txe_block;
        prev_rd_n = rd_n_o; prev_wr = wr_o;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int t = 0;
        while ((rx_src.size() || rx_exp.size() || tx_src.size() || tx_exp.size()
                || rx_valid_o) && t < 5000) begin
            @(negedge clk); t++;
        end
        chk(t < 5000, "R5", "queues did not drain", t, 0);
        cycles(30);
    endtask

    task automatic idle_outputs(input string req);
        chk(rd_n_o == 1, req, "rd strobe idle", rd_n_o, 1);
        chk(wr_o == 0, req, "wr strobe idle", wr_o, 0);
        chk(bus_oe_o == 0, req, "bus released", bus_oe_o, 0);
        chk(rx_valid_o == 0, req, "rx valid low", rx_valid_o, 0);
        chk(tx_ready_o == 0, req, "tx ready low", tx_ready_o, 0);
    endtask

    initial begin
        int p0;
        cycles(3);
        idle_outputs("R1");                       // R1 during reset
        rst = 0;
        cycles(3);
        idle_outputs("R1");                       // R1 after release

        // Reads with a consumer always ready
        rx_ready = 1;
        for (int i = 0; i < 5; i++) rx_src.push_back(8'h30 + 8'(i * 17));
        drain();

        // R5 backpressure: one read only, byte held
        rx_ready = 0; p0 = rd_pulses;
        rx_src.push_back(8'h00); rx_src.push_back(8'hFF); rx_src.push_back(8'h5A);
        cycles(80);
        chk(rd_pulses - p0 == 1, "R5", "reads while held", rd_pulses - p0, 1);
        chk(rx_valid_o && rx_data_o == 8'h00, "R5", "held byte", rx_data_o, 8'h00);
        rx_ready = 1;
        drain();

        // Writes
        for (int i = 0; i < 5; i++) tx_src.push_back(8'hA0 + 8'(i * 9));
        tx_valid = 1; tx_data = tx_src[0];
        drain();

        // R6: no space, nothing accepted or written
        txe_block = 1; cycles(20);
        p0 = wr_pulses; ready_seen = 0;
        tx_src.push_back(8'h81); tx_src.push_back(8'h7E);
        tx_valid = 1; tx_data = tx_src[0];
        cycles(60);
        chk(wr_pulses == p0, "R6", "write while no space", wr_pulses - p0, 0);
        chk(ready_seen == 0, "R6", "ready while no space", ready_seen, 0);
        txe_block = 0;
        drain();

        // R10: both directions loaded together
        last_kind = 0; rr_phase = 1;
        for (int i = 0; i < 6; i++) begin
            rx_src.push_back(8'h10 + 8'(i));
            tx_src.push_back(8'hC0 + 8'(i * 3));
        end
        tx_valid = 1; tx_data = tx_src[0];
        drain();
        rr_phase = 0;

        // R1: reset in the middle of a read strobe
        rx_src.push_back(8'h66);
        while (rd_n_o) @(negedge clk);
        cycles(1);
        rst = 1;
        cycles(1);
        idle_outputs("R1");
        rx_src.delete(); rx_exp.delete(); tx_src.delete(); tx_exp.delete();
        rd_hi = 1000; wr_lo = 1000; rxf_busy = 0; txe_busy = 0;
        cycles(2);
        rst = 0;
        cycles(5);
        idle_outputs("R1");

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule